// File: doc/BRIEF.md
# BT.656 Timing Reference Decoder

This block watches a byte-wide video stream that carries its own synchronisation codes, one byte per pixel clock. It looks for the fixed three-byte lead-in of a timing reference code: a byte of all ones followed by two bytes of all zeros. It then treats the next byte as a status word carrying the field, vertical-blanking and start/end-of-active-video flags, guarded by four protection bits.

The status word is checked against its protection bits. A single flipped bit is repaired. A word that cannot be repaired is reported on an error strobe and leaves the held field state untouched. Downstream logic uses the one-cycle start and end strobes to frame lines, the held field and blanking flags to frame pictures, and the active qualifier to pick out the picture bytes that follow a start code.

Top module: `tref_decoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all outputs are 0 after that edge, and the scanner returns to its searching state.
- R2: After the bytes 0xFF, 0x00, 0x00, the next byte is taken as the status word. If it is accepted and its H bit (bit 4) is 0, `sav_stb` is 1 for exactly the one cycle that follows the status byte.
- R3: An accepted status word with H = 1 gives `eav_stb` high for exactly the one cycle that follows the status byte. At most one of `sav_stb`, `eav_stb` and `code_err` is high in any cycle.
- R4: Status word layout: bit 7 is a marker that must be 1, bit 6 is F, bit 5 is V and bit 4 is H. An accepted word loads F into `fld` and V into `vblank` in the cycle after the status byte, and both hold their values until the next accepted word.
- R5: Bits 3..0 are protection bits with the values expected as V^H, F^H, F^V and F^V^H, from bit 3 down to bit 0. A word whose only error is a single wrong protection bit is accepted with its F, V and H unchanged.
- R6: A word with exactly one wrong bit among F, V and H is accepted with that bit corrected.
- R7: A word whose marker bit is 0, or that differs from every valid code in two or more of bits 6..0, pulses `code_err` for one cycle. It gives no `sav_stb` or `eav_stb`, and `fld` and `vblank` keep their values.
- R8: `active` goes high in the cycle after an accepted SAV word with V = 0 and stays high until a byte of 0xFF is on the bus. It is low during that byte and after it. An SAV with V = 1 leaves `active` low.
- R9: If a byte other than 0x00 follows the 0xFF or the first 0x00 of the lead-in, the search restarts on that byte's own value. So 0xFF 0xFF 0x00 0x00 is a complete lead-in, and a byte other than 0xFF returns the search to idle.
- R10: After a status word has been taken, the search restarts from idle on the following byte. The status byte itself never opens a new lead-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vid_byte | input | DATA_W (8) | Embedded-sync video byte |
| sav_stb | output | 1 | One-cycle strobe for an accepted start-of-active-video code |
| eav_stb | output | 1 | One-cycle strobe for an accepted end-of-active-video code |
| fld | output | 1 | Held field flag F |
| vblank | output | 1 | Held vertical blanking flag V |
| active | output | 1 | Qualifier for active-video bytes on `vid_byte` |
| code_err | output | 1 | One-cycle strobe for an uncorrectable status word |

## Verification
The strobes, `fld`, `vblank` and the internal active state pass through one register. They are therefore due in the cycle after the status byte is on the bus, while the next byte is presented. `active` also gates on the byte currently on the bus, so it falls in the same cycle that 0xFF appears. The bench drives each byte on the falling edge and compares every output 1 ns later. It uses a behavioural model that is advanced once per byte and decodes status words by nearest-codeword search. The comparison therefore sees the results of the edge that has just passed together with the byte now on the bus.

// File: rtl/tref_pkg.sv
// Package: shared types and helpers for the timing reference decoder.
// Assumes the status flags are ordered F, V, H from high to low.
package tref_pkg;

    localparam int FLAG_W = 3;
    localparam int PROT_W = 4;

    typedef enum logic [1:0] {
        SCAN_IDLE  = 2'd0,
        SCAN_ONES  = 2'd1,
        SCAN_ZERO1 = 2'd2,
        SCAN_ZERO2 = 2'd3
    } scan_state_t;

    typedef struct packed {
        logic fld;
        logic vbl;
        logic eav;
    } tref_flags_t;

    // Expected protection bits for flags {F,V,H}, returned high to low.
    function automatic logic [PROT_W-1:0] tref_prot(input logic [FLAG_W-1:0] fvh);
        tref_prot = {fvh[1] ^ fvh[0], fvh[2] ^ fvh[0], fvh[2] ^ fvh[1], ^fvh};
    endfunction

endpackage

// File: rtl/tref_preamble_scan.sv
// Module: lead-in scanner. Tracks the all-ones, zero, zero byte sequence.
// It flags the byte that follows that sequence as a status word.
// Assumes one byte per clock. A broken lead-in restarts on the breaking byte.
module tref_preamble_scan
    import tref_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] byte_in,
    output logic              status_now,
    output logic              ones_now
);

    localparam logic [DATA_W-1:0] ALL_ONES  = '1;
    localparam logic [DATA_W-1:0] ALL_ZEROS = '0;

    scan_state_t state_q;
    scan_state_t state_d;
    logic        is_zero;

    assign ones_now   = (byte_in == ALL_ONES);
    assign is_zero    = (byte_in == ALL_ZEROS);
    assign status_now = (state_q == SCAN_ZERO2);

    // Next-state choice; a mismatch restarts the search on the current byte.
    always_comb begin
        state_d = ones_now ? SCAN_ONES : SCAN_IDLE;
        unique case (state_q)
            SCAN_IDLE:  state_d = ones_now ? SCAN_ONES : SCAN_IDLE;
            SCAN_ONES:  if (is_zero) state_d = SCAN_ZERO1;
            SCAN_ZERO1: if (is_zero) state_d = SCAN_ZERO2;
            SCAN_ZERO2: state_d = SCAN_IDLE;
            default:    state_d = SCAN_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SCAN_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/tref_status_check.sv
// Module: status word checker. Computes the protection syndrome.
// It repairs a single wrong F/V/H bit and accepts a word whose only
// error is one protection bit. Purely combinational.
// Assumes the marker bit is the MSB, F/V/H sit below it, and the four
// protection bits follow. Any bits below those are ignored.
module tref_status_check
    import tref_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] word_in,
    output tref_flags_t       flags_out,
    output logic              word_ok
);

    localparam int MARK_POS = DATA_W - 1;
    localparam int FVH_HI   = DATA_W - 2;
    localparam int FVH_LO   = FVH_HI - FLAG_W + 1;
    localparam int PROT_HI  = FVH_LO - 1;
    localparam int PROT_LO  = PROT_HI - PROT_W + 1;

    logic [FLAG_W-1:0] fvh_rx;
    logic [FLAG_W-1:0] fvh_fix;
    logic [FLAG_W-1:0] flip;
    logic [PROT_W-1:0] prot_rx;
    logic [PROT_W-1:0] syndrome;
    logic              parity_only;

    assign fvh_rx   = word_in[FVH_HI:FVH_LO];
    assign prot_rx  = word_in[PROT_HI:PROT_LO];
    assign syndrome = prot_rx ^ tref_prot(fvh_rx);

    // One syndrome column per flag bit; a match marks that flag as flipped.
    for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_col
        localparam logic [FLAG_W-1:0] ONE_HOT = FLAG_W'(1) << gi;
        assign flip[gi] = (syndrome == tref_prot(ONE_HOT));
    end

    // Single protection-bit error: syndrome has exactly one bit set.
    assign parity_only = (syndrome != '0) &&
                         ((syndrome & (syndrome - PROT_W'(1))) == '0);

    // Apply the correction and decide whether the word is usable.
    always_comb begin
        fvh_fix   = fvh_rx ^ flip;
        word_ok   = word_in[MARK_POS] &
                    ((syndrome == '0) | parity_only | (|flip));
        flags_out = '{fld: fvh_fix[2], vbl: fvh_fix[1], eav: fvh_fix[0]};
    end

endmodule

// File: rtl/tref_sync_regs.sv
// Module: output register stage. Turns a decoded status word into strobes.
// It holds the field and blanking flags and the active-video state.
// Assumes status_now marks the cycle in which the status byte is on the bus.
module tref_sync_regs
    import tref_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        status_now,
    input  logic        ones_now,
    input  logic        word_ok,
    input  tref_flags_t flags_in,
    output logic        sav_stb,
    output logic        eav_stb,
    output logic        code_err,
    output logic        fld,
    output logic        vblank,
    output logic        active
);

    logic accept;
    logic act_q;

    assign accept = status_now & word_ok;

    // One-cycle strobes for accepted and rejected status words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sav_stb  <= 1'b0;
            eav_stb  <= 1'b0;
            code_err <= 1'b0;
        end else begin
            sav_stb  <= accept & ~flags_in.eav;
            eav_stb  <= accept &  flags_in.eav;
            code_err <= status_now & ~word_ok;
        end
    end

    // Held field and blanking flags, loaded only from accepted words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld    <= 1'b0;
            vblank <= 1'b0;
        end else if (accept) begin
            fld    <= flags_in.fld;
            vblank <= flags_in.vbl;
        end
    end

    // Active state: set by SAV outside blanking, cleared by an all-ones byte or EAV.
    always_ff @(posedge clk) begin
        if (!rst_n)        act_q <= 1'b0;
        else if (ones_now) act_q <= 1'b0;
        else if (accept)   act_q <= ~flags_in.eav & ~flags_in.vbl;
    end

    // Qualifier drops in the same cycle an all-ones byte appears.
    assign active = act_q & ~ones_now;

endmodule

// File: rtl/tref_decoder.sv
// Module: top of the embedded-sync timing reference decoder.
// Chains the lead-in scanner, the status word checker and the output registers.
// Assumes one video byte per rising clock edge and a synchronous active-low reset.
module tref_decoder
    import tref_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] vid_byte,
    output logic              sav_stb,
    output logic              eav_stb,
    output logic              fld,
    output logic              vblank,
    output logic              active,
    output logic              code_err
);

    logic        status_now;
    logic        ones_now;
    logic        word_ok;
    tref_flags_t flags;

    tref_preamble_scan #(.DATA_W(DATA_W)) i_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_in    (vid_byte),
        .status_now (status_now),
        .ones_now   (ones_now)
    );

    tref_status_check #(.DATA_W(DATA_W)) i_check (
        .word_in   (vid_byte),
        .flags_out (flags),
        .word_ok   (word_ok)
    );

    tref_sync_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_now (status_now),
        .ones_now   (ones_now),
        .word_ok    (word_ok),
        .flags_in   (flags),
        .sav_stb    (sav_stb),
        .eav_stb    (eav_stb),
        .code_err   (code_err),
        .fld        (fld),
        .vblank     (vblank),
        .active     (active)
    );

endmodule

// File: rtl/tref_decoder_chk.sv
// Module: port-level property checker for tref_decoder, attached by bind.
// Assumes only the top-level ports are visible.
module tref_decoder_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] vid_byte,
    input logic              sav_stb,
    input logic              eav_stb,
    input logic              fld,
    input logic              vblank,
    input logic              active,
    input logic              code_err
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    assert_sav_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sav_stb |=> !sav_stb);

    assert_eav_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eav_stb |=> !eav_stb);

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sav_stb, eav_stb, code_err}));

    assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sav_stb && !eav_stb) |-> ($stable(fld) && $stable(vblank)));

    assert_err_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> ($stable(fld) && $stable(vblank)));

    assert_active_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (sav_stb && !vblank));

    assert_active_not_on_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && vid_byte == ALL_ONES));

endmodule

bind tref_decoder tref_decoder_chk #(.DATA_W(DATA_W)) i_tref_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vid_byte (vid_byte),
    .sav_stb  (sav_stb),
    .eav_stb  (eav_stb),
    .fld      (fld),
    .vblank   (vblank),
    .active   (active),
    .code_err (code_err)
);

// File: tb/test_tref_decoder.sv
`timescale 1ns/1ps
module test_tref_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] vid_byte = 8'h10;
    logic       sav_stb, eav_stb, fld, vblank, active, code_err;

    int    n_checks = 0;
    int    n_fail = 0;
    string phase = "R1 reset";

    // Reference model state
    int   m_pos = 0;
    logic m_sav = 0, m_eav = 0, m_err = 0, m_fld = 0, m_vbl = 0, m_act = 0;

    always #10 clk = ~clk;

    tref_decoder i_tref_decoder (
        .clk(clk), .rst_n(rst_n), .vid_byte(vid_byte),
        .sav_stb(sav_stb), .eav_stb(eav_stb), .fld(fld), .vblank(vblank),
        .active(active), .code_err(code_err)
    );

    function automatic logic [7:0] code_byte(input logic f, input logic v, input logic h);
        code_byte = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic check_bit(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual %0b expected %0b", req, phase, what, act, exp);
        end
    endtask

    // Advance the model by one byte (the edge that samples it).
    task automatic model_step(input logic [7:0] b);
        int found;
        m_sav = 0; m_eav = 0; m_err = 0;
        if (b == 8'hFF) m_act = 0;
        case (m_pos)
            0: m_pos = (b == 8'hFF) ? 1 : 0;
            1, 2: m_pos = (b == 8'h00) ? m_pos + 1 : ((b == 8'hFF) ? 1 : 0);
            default: begin
                found = -1;
                if (b[7]) begin
                    for (int c = 0; c < 8; c++) begin
                        logic [7:0] cw;
                        cw = code_byte(c[2], c[1], c[0]);
                        if ($countones(cw ^ b) <= 1) found = c;
                    end
                end
                if (found < 0) m_err = 1;
                else begin
                    m_fld = found[2];
                    m_vbl = found[1];
                    if (found[0]) begin m_eav = 1; m_act = 0; end
                    else begin m_sav = 1; m_act = !found[1]; end
                end
                m_pos = 0;
            end
        endcase
    endtask

    task automatic drive(input logic [7:0] b);
        @(negedge clk);
        vid_byte = b;
        #1;
        check_bit(sav_stb,  m_sav, "R2", "sav_stb");
        check_bit(eav_stb,  m_eav, "R3", "eav_stb");
        check_bit(fld,      m_fld, "R4", "fld");
        check_bit(vblank,   m_vbl, "R4", "vblank");
        check_bit(code_err, m_err, "R7", "code_err");
        check_bit(active,   m_act && (b != 8'hFF), "R8", "active");
        if (rst_n) model_step(b);
    endtask

    task automatic send_code(input logic f, input logic v, input logic h, input logic [7:0] flip);
        drive(8'hFF); drive(8'h00); drive(8'h00);
        drive(code_byte(f, v, h) ^ flip);
    endtask

    task automatic send_data(input int n);
        for (int i = 0; i < n; i++) drive(8'h10 + 8'(i * 37 % 200));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: outputs low throughout reset, even with a full code on the bus
        phase = "R1 reset";
        send_code(1, 1, 0, 8'h00);
        drive(8'h10);
        @(negedge clk); rst_n = 1'b1;

        phase = "R2 R8 basic line";
        send_data(2);
        send_code(0, 0, 0, 8'h00);
        send_data(4); drive(8'h00); send_data(2);
        send_code(0, 0, 1, 8'h00);
        send_data(3);

        phase = "R4 blanking and field 2";
        send_code(1, 1, 0, 8'h00); send_data(3);
        send_code(1, 1, 1, 8'h00); send_data(2);
        send_code(1, 0, 0, 8'h00); send_data(3);
        send_code(1, 0, 1, 8'h00); send_data(2);
        send_code(0, 1, 0, 8'h00); send_data(2);

        phase = "R5 single protection-bit errors";
        for (int k = 0; k < 4; k++) begin
            send_code(k[0], 0, k[1], 8'(1 << k)); send_data(2);
        end

        phase = "R6 single flag-bit corrections";
        for (int k = 4; k < 7; k++) begin
            send_code(1, 0, 0, 8'(1 << k)); send_data(2);
            send_code(0, 1, 1, 8'(1 << k)); send_data(2);
        end

        phase = "R7 uncorrectable words";
        send_code(0, 0, 0, 8'h00); send_data(2);
        send_code(1, 1, 0, 8'h30); send_data(2);
        send_code(1, 0, 1, 8'h41); send_data(2);
        send_code(0, 0, 0, 8'h80); send_data(2);
        send_code(0, 1, 1, 8'h03); send_data(2);

        phase = "R9 lead-in restart";
        drive(8'hFF); drive(8'hFF); drive(8'h00); drive(8'h00); drive(code_byte(0, 0, 0));
        send_data(2);
        drive(8'hFF); drive(8'h01); drive(8'h00); drive(8'h00); drive(code_byte(1, 1, 1));
        send_data(2);
        drive(8'hFF); drive(8'h00); drive(8'h7F); drive(8'h00); drive(code_byte(0, 0, 1));
        send_data(2);
        drive(8'hFF); drive(8'h00); drive(8'hFF); drive(8'h00); drive(8'h00);
        drive(code_byte(1, 1, 0));
        send_data(2);

        phase = "R10 status byte does not open a lead-in";
        send_code(0, 0, 0, 8'h00); send_data(2);
        drive(8'hFF); drive(8'h00); drive(8'h00); drive(8'hFF);
        drive(8'h00); drive(8'h00); drive(code_byte(0, 0, 1));
        send_data(3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule